// File: doc/BRIEF.md
# Programmable DRAM Row Address Mapper

This block produces the upper DRAM row address bits 12 to 15 from a flat host address. A 32-bit configuration word holds one 4-bit selector for each row bit. The host address bit that feeds a row bit is found by adding that selector to a fixed base for the row bit. One selector code ties the row bit to zero, so a device with fewer row bits leaves the upper bits unused. A density-mode flag in the same word marks some addresses as invalid. This serves devices whose density is not a power of two, where the top quarter of the row space does not exist.

The configuration is static. Software may write it only while the memory controller is held in reset, and writes at any other time are dropped. The word can be read back at any time. The row bits and the invalid flag follow the host address combinationally. With the `OUT_REG` parameter set (the default), they pass through one register stage.

Top module: `row_addr_mapper`

## Requirements
- R1: While `rst_ni` is low, the stored configuration, `row_hi_o`, `addr_invalid_o` and `cfg_err_o` are all zero.
- R2: Row bit 12+k comes from host bit 18+k+s. Here s is the selector of that bit, and the selectors sit in config bits 3:0 (k=0), 11:8 (k=1), 19:16 (k=2) and 27:24 (k=3), with `row_hi_o[k]` carrying row bit 12+k.
- R3: A selector value of 15 forces its row bit to 0.
- R4: Selector values 12, 13 and 14 force their row bit to 0 and raise `cfg_err_o` while any selector holds one of them.
- R5: When config bit 31 is 1, `addr_invalid_o` is 1 exactly when the generated row bits 14 and 13 are both 1. When bit 31 is 0, `addr_invalid_o` is 0.
- R6: A write (`cfg_we_i` high) changes the stored configuration only if `ctrl_rst_i` is high at that clock edge. Otherwise it is ignored.
- R7: Config bits 30:28, 23:20, 15:12 and 7:4 always read as zero, whatever was written.
- R8: `cfg_rdata_o` shows the stored configuration at all times, independent of `ctrl_rst_i`.
- R9: With `OUT_REG`=1, `row_hi_o` and `addr_invalid_o` reflect the host address and configuration of the previous clock edge, so they have one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_rst_i | input | 1 | High while the memory controller is held in reset; enables config writes |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Stored configuration |
| haddr_i | input | 33 | Host address |
| row_hi_o | output | 4 | Row address bits 15:12 (bit 0 = row bit 12) |
| addr_invalid_o | output | 1 | Address falls in the missing row range |
| cfg_err_o | output | 1 | A selector holds an unsupported code |

## Verification
The assertions check four things on every cycle:
- the configuration never changes at an edge where `ctrl_rst_i` is low;
- the unused configuration bits stay zero;
- the invalid flag appears only with row bits 14:13 at 11 and never while the density mode is off;
- a row bit whose selector has held 15 or a code from 12 to 14 stays zero.

Only the bench's scenarios can show that the right host bit is routed for each base and selector, including the highest index 32. The same applies to the error flag for codes 12 to 14, to the one-cycle latency, and to the clearing of the configuration by reset. The bench covers these with a behavioural reference model that it compares on every clock.

// File: rtl/row_map_pkg.sv
package row_map_pkg;
  localparam int unsigned CFG_W        = 32;
  localparam int unsigned SEL_W        = 4;
  localparam int unsigned ROW_N        = 4;
  localparam int unsigned ROW_LSB      = 12;
  localparam int unsigned BASE_LSB     = 18;
  localparam int unsigned FIELD_STRIDE = 8;
  localparam int unsigned MODE_BIT     = 31;
  localparam int unsigned MAX_SEL      = 11;
  localparam int unsigned HADDR_W      = BASE_LSB + ROW_N - 1 + MAX_SEL + 1;
  localparam int unsigned ZERO_SEL     = (1 << SEL_W) - 1;

  function automatic logic [CFG_W-1:0] cfg_keep_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    for (int k = 0; k < int'(ROW_N); k++)
      for (int b = 0; b < int'(SEL_W); b++)
        m[k*FIELD_STRIDE+b] = 1'b1;
    m[MODE_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/row_map_cfg.sv
module row_map_cfg #(
  parameter int unsigned           CFG_W     = 32,
  parameter logic [CFG_W-1:0]      KEEP_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_rst_i,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  // static register: only loadable while controller is held in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cfg_q <= '0;
    else if (we_i && ctrl_rst_i) cfg_q <= wdata_i & KEEP_MASK;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/row_bit_sel.sv
module row_bit_sel #(
  parameter int unsigned HADDR_W = 33,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned BASE    = 18,
  parameter int unsigned MAX_SEL = 11
) (
  input  logic [HADDR_W-1:0] haddr_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               bit_o,
  output logic               bad_o
);
  localparam logic [SEL_W-1:0] MAX_CODE  = SEL_W'(MAX_SEL);
  localparam logic [SEL_W-1:0] ZERO_CODE = '1;

  logic [HADDR_W-1:0] shifted;
  logic               in_range;

  assign in_range = (sel_i <= MAX_CODE);
  assign shifted  = haddr_i >> (BASE + int'(sel_i));
  assign bit_o    = in_range & shifted[0];
  assign bad_o    = !in_range && (sel_i != ZERO_CODE);
endmodule

// File: rtl/row_map_out.sv
module row_map_out #(
  parameter int unsigned ROW_N   = 4,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_N-1:0] row_d_i,
  input  logic             inv_d_i,
  output logic [ROW_N-1:0] row_o,
  output logic             inv_o
);
  if (OUT_REG) begin : g_reg
    logic [ROW_N-1:0] row_q;
    logic             inv_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
        inv_q <= 1'b0;
      end else begin
        row_q <= row_d_i;
        inv_q <= inv_d_i;
      end
    end
    assign row_o = row_q;
    assign inv_o = inv_q;
  end else begin : g_comb
    assign row_o = row_d_i;
    assign inv_o = inv_d_i;
  end
endmodule

// File: rtl/row_addr_mapper.sv
module row_addr_mapper
  import row_map_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_rst_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W-1:0]   cfg_rdata_o,
  input  logic [HADDR_W-1:0] haddr_i,
  output logic [ROW_N-1:0]   row_hi_o,
  output logic               addr_invalid_o,
  output logic               cfg_err_o
);
  localparam logic [CFG_W-1:0] KEEP = cfg_keep_mask();
  localparam int unsigned INV_A = 13 - ROW_LSB;
  localparam int unsigned INV_B = 14 - ROW_LSB;

  logic [CFG_W-1:0] cfg;
  logic [ROW_N-1:0] row_d;
  logic [ROW_N-1:0] bad;
  logic             inv_d;

  row_map_cfg #(.CFG_W(CFG_W), .KEEP_MASK(KEEP)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_rst_i (ctrl_rst_i),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .cfg_o      (cfg)
  );

  for (genvar k = 0; k < int'(ROW_N); k++) begin : g_row
    row_bit_sel #(
      .HADDR_W (HADDR_W),
      .SEL_W   (SEL_W),
      .BASE    (BASE_LSB + k),
      .MAX_SEL (MAX_SEL)
    ) u_sel (
      .haddr_i (haddr_i),
      .sel_i   (cfg[k*FIELD_STRIDE +: SEL_W]),
      .bit_o   (row_d[k]),
      .bad_o   (bad[k])
    );
  end

  // non-power-of-two density: top quarter of row space absent
  assign inv_d = cfg[MODE_BIT] & row_d[INV_A] & row_d[INV_B];

  row_map_out #(.ROW_N(ROW_N), .OUT_REG(OUT_REG)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .row_d_i (row_d),
    .inv_d_i (inv_d),
    .row_o   (row_hi_o),
    .inv_o   (addr_invalid_o)
  );

  assign cfg_rdata_o = cfg;
  assign cfg_err_o   = |bad;
endmodule

// File: rtl/row_addr_mapper_chk.sv
module row_addr_mapper_chk
  import row_map_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_rst_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic [ROW_N-1:0] row_hi_o,
  input logic             addr_invalid_o
);
  localparam logic [CFG_W-1:0] KEEP = cfg_keep_mask();

  a_r6_static_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rst_i |=> $stable(cfg_rdata_o));

  a_r7_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & ~KEEP) == '0);

  a_r5_invalid_rows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_invalid_o |-> (row_hi_o[2:1] == 2'b11));

  a_r5_mode_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rdata_o[MODE_BIT] && !$past(cfg_rdata_o[MODE_BIT])) |-> !addr_invalid_o);

  for (genvar k = 0; k < int'(ROW_N); k++) begin : g_chk
    logic [SEL_W-1:0] sel;
    assign sel = cfg_rdata_o[k*FIELD_STRIDE +: SEL_W];

    a_r3_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == SEL_W'(ZERO_SEL) && $past(sel) == SEL_W'(ZERO_SEL)) |-> !row_hi_o[k]);

    a_r4_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel > SEL_W'(MAX_SEL) && $past(sel) > SEL_W'(MAX_SEL)) |-> !row_hi_o[k]);
  end
endmodule

bind row_addr_mapper row_addr_mapper_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ctrl_rst_i     (ctrl_rst_i),
  .cfg_rdata_o    (cfg_rdata_o),
  .row_hi_o       (row_hi_o),
  .addr_invalid_o (addr_invalid_o)
);

// File: tb/row_addr_mapper_tb_top.sv
module row_addr_mapper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEEP = 32'h8F0F0F0F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_rst_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [32:0] haddr_i = '0;
  logic [3:0]  row_hi_o;
  logic        addr_invalid_o;
  logic        cfg_err_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] model_cfg = '0;

  row_addr_mapper dut_i (
    .clk_i, .rst_ni, .ctrl_rst_i, .cfg_we_i, .cfg_wdata_i, .cfg_rdata_o,
    .haddr_i, .row_hi_o, .addr_invalid_o, .cfg_err_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [3:0] ref_row(logic [31:0] c, logic [32:0] a);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int s = int'((c >> (8*k)) & 32'hF);
      if (s <= 11) r[k] = a[18 + k + s];
    end
    return r;
  endfunction

  function automatic logic ref_err(logic [31:0] c);
    logic e = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int s = int'((c >> (8*k)) & 32'hF);
      if (s >= 12 && s <= 14) e = 1'b1;
    end
    return e;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; drives, crosses one posedge, checks at next negedge
  task automatic step(string req, logic [32:0] a, logic we, logic [31:0] wd, logic crst);
    logic [3:0] er;
    logic       ei;
    haddr_i = a; cfg_we_i = we; cfg_wdata_i = wd; ctrl_rst_i = crst;
    @(posedge clk_i);
    er = ref_row(model_cfg, a);
    ei = model_cfg[31] & er[2] & er[1];
    if (we && crst) model_cfg = wd & KEEP;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk(req, "row", 64'(row_hi_o), 64'(er));
    chk(req, "invalid", 64'(addr_invalid_o), 64'(ei));
    chk("R8", "rdata", 64'(cfg_rdata_o), 64'(model_cfg));
    chk("R4", "cfg_err", 64'(cfg_err_o), 64'(ref_err(model_cfg)));
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    haddr_i = '1; ctrl_rst_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1", "row", 64'(row_hi_o), 0);
    chk("R1", "invalid", 64'(addr_invalid_o), 0);
    chk("R1", "rdata", 64'(cfg_rdata_o), 0);
    chk("R1", "cfg_err", 64'(cfg_err_o), 0);
    rst_ni = 1'b1;

    // R2 defaults: selectors 0 -> host bits 18..21
    step("R2", 33'h0_0004_0000, 0, 0, 1);
    step("R2", 33'h0_0008_0000, 0, 0, 1);
    step("R2", 33'h0_0010_0000, 0, 0, 1);
    step("R2", 33'h0_0020_0000, 0, 0, 1);
    step("R2", 33'h1_FFC3_FFFF, 0, 0, 1);

    // R6 write outside controller reset is dropped
    step("R6", 33'h0_003C_0000, 1, 32'h0B0B_0B0B, 0);
    chk("R6", "rdata", 64'(cfg_rdata_o), 0);
    step("R6", 33'h0_003C_0000, 0, 0, 0);

    // R3/R7 all ones: selectors 15, unused bits dropped
    step("R3", '1, 1, 32'hFFFF_FFFF, 1);
    chk("R7", "unused", 64'(cfg_rdata_o & ~KEEP), 0);
    chk("R7", "rdata", 64'(cfg_rdata_o), 64'(32'h8F0F_0F0F));
    step("R3", '1, 0, 0, 0);
    step("R3", 33'h1_5555_5555, 0, 0, 0);

    // R2/R5: sels 3,7,10,11 -> bits 21,26,30,32; mode on
    step("R2", 33'h0, 1, 32'h8B0A_0703, 1);
    step("R5", 33'h0_4400_0000, 0, 0, 0);
    step("R5", 33'h0_0400_0000, 0, 0, 0);
    step("R5", 33'h0_4000_0000, 0, 0, 0);
    step("R2", 33'h1_0020_0000, 0, 0, 0);
    step("R9", 33'h1_4420_0000, 0, 0, 0);
    step("R9", 33'h0_0000_0000, 0, 0, 0);
    step("R9", 33'h0_4400_0000, 0, 0, 0);

    // R5 mode off, same rows
    step("R5", 33'h0, 1, 32'h0B0A_0703, 1);
    step("R5", 33'h1_4420_0000, 0, 0, 1);

    // R4 reserved codes 12..14; sel 11 on row 12 -> bit 29
    step("R4", 33'h0, 1, 32'h0C0D_0E0B, 1);
    step("R4", '1, 0, 0, 0);
    step("R4", 33'h0_2000_0000, 0, 0, 0);
    step("R4", 33'h0, 1, 32'h0000_000C, 1);
    step("R4", '1, 0, 0, 1);

    // R1 reset clears configuration
    step("R1", 33'h0, 1, 32'h8B0A_0703, 1);
    rst_ni = 1'b0;
    #1;
    model_cfg = '0;
    chk("R1", "rdata", 64'(cfg_rdata_o), 0);
    chk("R1", "row", 64'(row_hi_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step("R1", 33'h0_003C_0000, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule